// File: doc/BRIEF.md
# Programmable Logic Array with Fault Injection

This block is a two-level programmable logic array: an AND plane builds product terms from the true and complemented forms of the input vector, and an OR plane combines chosen product terms into each output. Every crosspoint bit sits in a register written over a simple address/data port. The block is intended as a fault-modelling target. Test sequences can be tried against known defects, and the response of a faulty array can be compared with that of a healthy one.

Beside each programmed plane sits a fault plane of the same shape. A fault bit toggles one crosspoint, so it can remove a literal or add one in the AND plane, and drop or add a product in the OR plane. Stuck-at overrides, each an enable mask plus a value mask, sit on four kinds of site: the inputs, the inverter outputs, the product lines and the outputs. One bridge register shorts two chosen product lines. Both lines then carry either the AND or the OR of their fault-free values. The product lines are brought out for observation. The data path from the inputs to the outputs is combinational.

Top module: `pla_fault_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every configuration register clears. After that edge every product line reads 1, because a term with no literals is constant 1, and every output reads 0.
- R2: Product line p is the AND of the literals selected by the effective AND row p. Bit 2i of a row selects input i and bit 2i+1 selects its complement. A row that selects nothing gives 1.
- R3: Output o is the OR of the product lines selected by the effective OR row o, where bit p selects product p.
- R4: A write sets its register at the clock edge where `cfg_we` is high, and it is visible from that edge on, not before. Address map with the default sizes (P products, O outputs): AND rows at 0..P-1, AND fault rows at P..2P-1, OR rows at 2P..2P+O-1, OR fault rows at 2P+O..2P+2O-1. Stuck registers follow from 2P+2O in this order: input enable, input value, inverter enable, inverter value, product enable, product value, output enable, output value. The bridge register comes next. Writes to any higher address change nothing.
- R5: The effective AND row is the programmed row XOR its fault row. Clearing a literal widens the term (growth). Adding a literal narrows it (shrinkage). Adding the complement of a literal already present makes the term constant 0.
- R6: The effective OR row is the programmed row XOR its fault row. Toggling a set bit removes that product from the output, and toggling a clear bit adds it.
- R7: An enabled input stuck site forces input i to its value bit. Both the true literal and the inverter see the forced value.
- R8: An enabled inverter stuck site forces only the complement literal of input i. The true literal is left unchanged.
- R9: An enabled product stuck site forces that product line on `prod_out` and in the OR plane. It takes precedence over the bridge.
- R10: An enabled output stuck site forces that output bit.
- R11: Bridge register: bit 0 enable, bit 1 mode (0 wired-AND, 1 wired-OR), bits 4:2 line a, bits 7:5 line b. When the bridge is enabled and both indices are below P, lines a and b both carry the AND or OR of their unbridged values. An index of P or above disables the bridge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (5) | Configuration register address |
| cfg_wdata | input | DW (16) | Configuration write data, right-aligned |
| pla_in | input | N_IN (4) | Array input vector |
| pla_out | output | N_OUT (3) | Array output vector |
| prod_out | output | N_PROD (6) | Product line values after faults |

## Verification
The bench goes after the spots where a fault class is easily applied at the wrong point in the chain. An input stuck-at must reach the inverter. An inverter stuck-at must leave the true literal alone, and a design that forced the input instead would flip both literals. A complement literal added to a term must turn it off entirely. A product stuck-at must override a bridge, or the two shorted lines stay equal when they should differ. An out-of-range bridge index must leave the lines untouched, and writes above the map must leave every output unchanged. The write timing is checked on both sides of the edge, so an array that applied a write early, or one cycle late, shows a mismatch.

// File: rtl/pla_pkg.sv
// Shared definitions for the fault-injecting logic array.
// Assumes the stuck register order below matches the address map in BRIEF R4.
package pla_pkg;
    typedef enum logic {
        BR_WIRED_AND = 1'b0,
        BR_WIRED_OR  = 1'b1
    } br_mode_e;

    // Offsets of the stuck-at registers within their block.
    localparam int ST_IN_EN   = 0;
    localparam int ST_IN_VAL  = 1;
    localparam int ST_INV_EN  = 2;
    localparam int ST_INV_VAL = 3;
    localparam int ST_PR_EN   = 4;
    localparam int ST_PR_VAL  = 5;
    localparam int ST_OUT_EN  = 6;
    localparam int ST_OUT_VAL = 7;
    localparam int ST_COUNT   = 8;
endpackage

// File: rtl/pla_cfg_regs.sv
// Configuration register file: programmed planes, fault planes, stuck masks and bridge.
// Assumes DW covers the widest row (2*N_IN, N_PROD, N_OUT, 2+2*PW) and that
// the map fits in 2**AW addresses. It outputs the effective (XORed) plane masks.
module pla_cfg_regs
    import pla_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_PROD = 6,
    parameter int N_OUT  = 3,
    parameter int DW     = 16,
    parameter int AW     = 5,
    localparam int LW    = 2 * N_IN,
    localparam int PW    = $clog2(N_PROD)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [AW-1:0]                  cfg_addr,
    input  logic [DW-1:0]                  cfg_wdata,
    output logic [N_PROD-1:0][LW-1:0]      and_eff,
    output logic [N_OUT-1:0][N_PROD-1:0]   or_eff,
    output logic [N_IN-1:0]                in_en,
    output logic [N_IN-1:0]                in_val,
    output logic [N_IN-1:0]                inv_en,
    output logic [N_IN-1:0]                inv_val,
    output logic [N_PROD-1:0]              pr_en,
    output logic [N_PROD-1:0]              pr_val,
    output logic [N_OUT-1:0]               out_en,
    output logic [N_OUT-1:0]               out_val,
    output logic                           br_en,
    output br_mode_e                       br_mode,
    output logic [PW-1:0]                  br_a,
    output logic [PW-1:0]                  br_b
);
    localparam int A_ANDP = 0;
    localparam int A_ANDF = N_PROD;
    localparam int A_ORP  = 2 * N_PROD;
    localparam int A_ORF  = 2 * N_PROD + N_OUT;
    localparam int A_ST   = 2 * N_PROD + 2 * N_OUT;
    localparam int A_BR   = A_ST + ST_COUNT;
    localparam int BRW    = 2 + 2 * PW;

    logic [N_PROD-1:0][LW-1:0]    and_prog, and_flt;
    logic [N_OUT-1:0][N_PROD-1:0] or_prog, or_flt;
    logic [BRW-1:0]               br_reg;

    function automatic logic hit(input logic [AW-1:0] a, input int target);
        return a == AW'(target);
    endfunction

    // Plane rows: programmed and fault masks, one address each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            and_prog <= '0;
            and_flt  <= '0;
            or_prog  <= '0;
            or_flt   <= '0;
        end else if (cfg_we) begin
            for (int p = 0; p < N_PROD; p++) begin
                if (hit(cfg_addr, A_ANDP + p)) and_prog[p] <= cfg_wdata[LW-1:0];
                if (hit(cfg_addr, A_ANDF + p)) and_flt[p]  <= cfg_wdata[LW-1:0];
            end
            for (int o = 0; o < N_OUT; o++) begin
                if (hit(cfg_addr, A_ORP + o)) or_prog[o] <= cfg_wdata[N_PROD-1:0];
                if (hit(cfg_addr, A_ORF + o)) or_flt[o]  <= cfg_wdata[N_PROD-1:0];
            end
        end
    end

    // Stuck-at enable/value masks and the bridge selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_en   <= '0;
            in_val  <= '0;
            inv_en  <= '0;
            inv_val <= '0;
            pr_en   <= '0;
            pr_val  <= '0;
            out_en  <= '0;
            out_val <= '0;
            br_reg  <= '0;
        end else if (cfg_we) begin
            if (hit(cfg_addr, A_ST + ST_IN_EN))   in_en   <= cfg_wdata[N_IN-1:0];
            if (hit(cfg_addr, A_ST + ST_IN_VAL))  in_val  <= cfg_wdata[N_IN-1:0];
            if (hit(cfg_addr, A_ST + ST_INV_EN))  inv_en  <= cfg_wdata[N_IN-1:0];
            if (hit(cfg_addr, A_ST + ST_INV_VAL)) inv_val <= cfg_wdata[N_IN-1:0];
            if (hit(cfg_addr, A_ST + ST_PR_EN))   pr_en   <= cfg_wdata[N_PROD-1:0];
            if (hit(cfg_addr, A_ST + ST_PR_VAL))  pr_val  <= cfg_wdata[N_PROD-1:0];
            if (hit(cfg_addr, A_ST + ST_OUT_EN))  out_en  <= cfg_wdata[N_OUT-1:0];
            if (hit(cfg_addr, A_ST + ST_OUT_VAL)) out_val <= cfg_wdata[N_OUT-1:0];
            if (hit(cfg_addr, A_BR))              br_reg  <= cfg_wdata[BRW-1:0];
        end
    end

    // Effective planes: one fault bit toggles one crosspoint.
    always_comb begin
        and_eff = and_prog ^ and_flt;
        or_eff  = or_prog ^ or_flt;
    end

    assign br_en   = br_reg[0];
    assign br_mode = br_mode_e'(br_reg[1]);
    assign br_a    = br_reg[2 +: PW];
    assign br_b    = br_reg[2 + PW +: PW];
endmodule

// File: rtl/pla_and_plane.sv
// AND plane: applies input and inverter stuck-at faults, then forms each product
// as the AND of its selected literals. Row bit 2i is input i and bit 2i+1 its
// complement. An empty row yields 1.
module pla_and_plane #(
    parameter int N_IN   = 4,
    parameter int N_PROD = 6,
    localparam int LW    = 2 * N_IN
) (
    input  logic [N_IN-1:0]            pla_in,
    input  logic [N_IN-1:0]            in_en,
    input  logic [N_IN-1:0]            in_val,
    input  logic [N_IN-1:0]            inv_en,
    input  logic [N_IN-1:0]            inv_val,
    input  logic [N_PROD-1:0][LW-1:0]  and_eff,
    output logic [N_PROD-1:0]          prod_raw
);
    logic [N_IN-1:0] in_eff, inv_eff;
    logic [LW-1:0]   lit;

    // Input site override, then the inverter driven from the forced input.
    always_comb begin
        in_eff  = (pla_in & ~in_en) | (in_val & in_en);
        inv_eff = (~in_eff & ~inv_en) | (inv_val & inv_en);
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit[2*i]   = in_eff[i];
        assign lit[2*i+1] = inv_eff[i];
    end

    // Unselected literals read as 1 so they do not affect the AND.
    for (genvar p = 0; p < N_PROD; p++) begin : g_term
        assign prod_raw[p] = &(lit | ~and_eff[p]);
    end
endmodule

// File: rtl/pla_prod_fault.sv
// Product-line fault stage: optional wired-AND/OR bridge of two lines, then
// product stuck-at overrides (stuck wins over the bridge). A bridge index of
// N_PROD or above disables the bridge.
module pla_prod_fault
    import pla_pkg::*;
#(
    parameter int N_PROD = 6,
    localparam int PW    = $clog2(N_PROD)
) (
    input  logic [N_PROD-1:0] prod_raw,
    input  logic              br_en,
    input  br_mode_e          br_mode,
    input  logic [PW-1:0]     br_a,
    input  logic [PW-1:0]     br_b,
    input  logic [N_PROD-1:0] pr_en,
    input  logic [N_PROD-1:0] pr_val,
    output logic [N_PROD-1:0] prod_fin
);
    logic [N_PROD-1:0] bridged;
    logic              br_ok, wired;

    // Short the two chosen lines onto a shared wired value.
    always_comb begin
        bridged = prod_raw;
        br_ok   = br_en && (int'(br_a) < N_PROD) && (int'(br_b) < N_PROD);
        wired   = 1'b0;
        if (br_ok) begin
            wired = (br_mode == BR_WIRED_OR) ? (prod_raw[br_a] | prod_raw[br_b])
                                             : (prod_raw[br_a] & prod_raw[br_b]);
            bridged[br_a] = wired;
            bridged[br_b] = wired;
        end
    end

    // Stuck-at override on each product line.
    assign prod_fin = (bridged & ~pr_en) | (pr_val & pr_en);
endmodule

// File: rtl/pla_or_plane.sv
// OR plane: each output is the OR of its selected product lines, then output
// stuck-at overrides are applied.
module pla_or_plane #(
    parameter int N_PROD = 6,
    parameter int N_OUT  = 3
) (
    input  logic [N_PROD-1:0]             prod_fin,
    input  logic [N_OUT-1:0][N_PROD-1:0]  or_eff,
    input  logic [N_OUT-1:0]              out_en,
    input  logic [N_OUT-1:0]              out_val,
    output logic [N_OUT-1:0]              pla_out
);
    logic [N_OUT-1:0] sum;

    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        assign sum[o] = |(prod_fin & or_eff[o]);
    end

    // Output site override.
    assign pla_out = (sum & ~out_en) | (out_val & out_en);
endmodule

// File: rtl/pla_fault_top.sv
// Top level: configuration registers plus a combinational
// AND plane -> product fault stage -> OR plane data path.
// Assumes a synchronous active-low reset. Writes take effect at the next edge.
module pla_fault_top
    import pla_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_PROD = 6,
    parameter int N_OUT  = 3,
    parameter int DW     = 16,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic [N_IN-1:0]   pla_in,
    output logic [N_OUT-1:0]  pla_out,
    output logic [N_PROD-1:0] prod_out
);
    localparam int LW = 2 * N_IN;
    localparam int PW = $clog2(N_PROD);

    logic [N_PROD-1:0][LW-1:0]    and_eff;
    logic [N_OUT-1:0][N_PROD-1:0] or_eff;
    logic [N_IN-1:0]              in_en, in_val, inv_en, inv_val;
    logic [N_PROD-1:0]            pr_en, pr_val, prod_raw;
    logic [N_OUT-1:0]             out_en, out_val;
    logic                         br_en;
    br_mode_e                     br_mode;
    logic [PW-1:0]                br_a, br_b;

    pla_cfg_regs #(.N_IN(N_IN), .N_PROD(N_PROD), .N_OUT(N_OUT), .DW(DW), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .and_eff(and_eff), .or_eff(or_eff),
        .in_en(in_en), .in_val(in_val), .inv_en(inv_en), .inv_val(inv_val),
        .pr_en(pr_en), .pr_val(pr_val), .out_en(out_en), .out_val(out_val),
        .br_en(br_en), .br_mode(br_mode), .br_a(br_a), .br_b(br_b)
    );

    pla_and_plane #(.N_IN(N_IN), .N_PROD(N_PROD)) u_and (
        .pla_in(pla_in), .in_en(in_en), .in_val(in_val), .inv_en(inv_en), .inv_val(inv_val),
        .and_eff(and_eff), .prod_raw(prod_raw)
    );

    pla_prod_fault #(.N_PROD(N_PROD)) u_pfault (
        .prod_raw(prod_raw), .br_en(br_en), .br_mode(br_mode), .br_a(br_a), .br_b(br_b),
        .pr_en(pr_en), .pr_val(pr_val), .prod_fin(prod_out)
    );

    pla_or_plane #(.N_PROD(N_PROD), .N_OUT(N_OUT)) u_or (
        .prod_fin(prod_out), .or_eff(or_eff), .out_en(out_en), .out_val(out_val),
        .pla_out(pla_out)
    );
endmodule

// File: rtl/pla_fault_chk.sv
// Property checker for pla_fault_top, attached by bind below.
// It watches the ports and the decoded fault controls.
module pla_fault_chk #(
    parameter int N_IN   = 4,
    parameter int N_PROD = 6,
    parameter int N_OUT  = 3,
    parameter int DW     = 16,
    parameter int AW     = 5,
    localparam int PW    = $clog2(N_PROD)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [AW-1:0]     cfg_addr,
    input logic [DW-1:0]     cfg_wdata,
    input logic [N_OUT-1:0]  pla_out,
    input logic [N_PROD-1:0] prod_out,
    input logic [N_OUT-1:0]  out_en,
    input logic [N_OUT-1:0]  out_val,
    input logic [N_PROD-1:0] pr_en,
    input logic [N_PROD-1:0] pr_val,
    input logic              br_en,
    input logic [PW-1:0]     br_a,
    input logic [PW-1:0]     br_b
);
    localparam int A_OUT_EN = 2 * N_PROD + 2 * N_OUT + 6;

    logic br_live;
    assign br_live = br_en && (int'(br_a) < N_PROD) && (int'(br_b) < N_PROD);

    // R10
    out_stuck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pla_out ^ out_val) & out_en) == '0);

    // R9
    prod_stuck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((prod_out ^ pr_val) & pr_en) == '0);

    // R11
    bridge_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_live && !pr_en[br_a] && !pr_en[br_b]) |-> (prod_out[br_a] == prod_out[br_b]));

    // R4
    write_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == AW'(A_OUT_EN)) |=> (out_en == $past(cfg_wdata[N_OUT-1:0])));
endmodule

bind pla_fault_top pla_fault_chk #(
    .N_IN(N_IN), .N_PROD(N_PROD), .N_OUT(N_OUT), .DW(DW), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pla_out(pla_out), .prod_out(prod_out), .out_en(out_en), .out_val(out_val),
    .pr_en(pr_en), .pr_val(pr_val), .br_en(br_en), .br_a(br_a), .br_b(br_b)
);

// File: tb/tb_pla_fault_top.sv
// Self-checking bench: directed fault cases plus seeded random traffic,
// compared against a reference model built from the requirements.
module tb_pla_fault_top;
    localparam int NI = 4, NP = 6, NO = 3, DW = 16, AW = 5, LW = 8;
    localparam int A_ANDF = NP, A_ORP = 2*NP, A_ORF = 2*NP + NO, A_ST = 2*NP + 2*NO;
    localparam int A_BR = A_ST + 8;

    logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [NI-1:0] pla_in = '0;
    logic [NO-1:0] pla_out;
    logic [NP-1:0] prod_out;

    int checks = 0, fails = 0;

    logic [LW-1:0] m_andp [NP];
    logic [LW-1:0] m_andf [NP];
    logic [NP-1:0] m_orp  [NO];
    logic [NP-1:0] m_orf  [NO];
    logic [DW-1:0] m_st   [8];
    logic [DW-1:0] m_br;
    logic [NP-1:0] e_prod;
    logic [NO-1:0] e_out;

    always #5 clk = ~clk;

    pla_fault_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pla_in(pla_in), .pla_out(pla_out), .prod_out(prod_out)
    );

    function automatic void model_clear();
        for (int k = 0; k < NP; k++) begin m_andp[k] = '0; m_andf[k] = '0; end
        for (int k = 0; k < NO; k++) begin m_orp[k] = '0; m_orf[k] = '0; end
        for (int k = 0; k < 8; k++) m_st[k] = '0;
        m_br = '0;
    endfunction

    function automatic void model_write(input int a, input logic [DW-1:0] d);
        if (a < NP)              m_andp[a] = d[LW-1:0];
        else if (a < A_ORP)      m_andf[a-A_ANDF] = d[LW-1:0];
        else if (a < A_ORF)      m_orp[a-A_ORP] = d[NP-1:0];
        else if (a < A_ST)       m_orf[a-A_ORF] = d[NP-1:0];
        else if (a < A_BR)       m_st[a-A_ST] = d;
        else if (a == A_BR)      m_br = {8'h00, d[7:0]};
    endfunction

    // Reference behaviour of R2, R3, R5..R11.
    function automatic void model_eval(input logic [NI-1:0] x);
        logic [NI-1:0] xi, xn;
        logic [LW-1:0] row;
        logic t, w;
        int a, b;
        xi = (x & ~m_st[0][NI-1:0]) | (m_st[1][NI-1:0] & m_st[0][NI-1:0]);
        xn = (~xi & ~m_st[2][NI-1:0]) | (m_st[3][NI-1:0] & m_st[2][NI-1:0]);
        for (int p = 0; p < NP; p++) begin
            row = m_andp[p] ^ m_andf[p];
            t = 1'b1;
            for (int i = 0; i < NI; i++) begin
                if (row[2*i])   t = t & xi[i];
                if (row[2*i+1]) t = t & xn[i];
            end
            e_prod[p] = t;
        end
        a = int'(m_br[4:2]);
        b = int'(m_br[7:5]);
        if (m_br[0] && a < NP && b < NP) begin
            w = m_br[1] ? (e_prod[a] | e_prod[b]) : (e_prod[a] & e_prod[b]);
            e_prod[a] = w;
            e_prod[b] = w;
        end
        e_prod = (e_prod & ~m_st[4][NP-1:0]) | (m_st[5][NP-1:0] & m_st[4][NP-1:0]);
        for (int o = 0; o < NO; o++) e_out[o] = |(e_prod & (m_orp[o] ^ m_orf[o]));
        e_out = (e_out & ~m_st[6][NO-1:0]) | (m_st[7][NO-1:0] & m_st[6][NO-1:0]);
    endfunction

    task automatic compare(input string req);
        model_eval(pla_in);
        checks += 2;
        if (prod_out !== e_prod) begin
            fails++;
            $display("FAIL %s prod_out in=%b actual=%b expected=%b", req, pla_in, prod_out, e_prod);
        end
        if (pla_out !== e_out) begin
            fails++;
            $display("FAIL %s pla_out in=%b actual=%b expected=%b", req, pla_in, pla_out, e_out);
        end
    endtask

    // Drive one input vector between edges and compare.
    task automatic check_in(input logic [NI-1:0] x, input string req);
        @(negedge clk);
        pla_in = x;
        #1;
        compare(req);
    endtask

    task automatic sweep(input string req);
        for (int v = 0; v < 16; v++) check_in(NI'(v), req);
    endtask

    // Write one register. Before the edge the old values must still hold (R4).
    task automatic wr(input int a, input logic [DW-1:0] d, input bit pre_check);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = AW'(a);
        cfg_wdata = d;
        #1;
        if (pre_check) compare("R4 pre-edge");
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic clear_faults();
        for (int k = 0; k < NP; k++) wr(A_ANDF + k, '0, 1'b0);
        for (int k = 0; k < NO; k++) wr(A_ORF + k, '0, 1'b0);
        for (int k = 0; k < 9; k++)  wr(A_ST + k, '0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D));
        model_clear();
        // R1: reset state
        repeat (3) @(posedge clk);
        check_in(4'b1010, "R1");
        @(negedge clk) rst_n = 1'b1;
        check_in(4'b0101, "R1");

        // R2, R3: row0 = x0 & ~x1, row1 = x2, out0 = p0|p1, out1 = p1
        wr(0, 16'h0009, 1'b1);
        wr(1, 16'h0010, 1'b1);
        wr(A_ORP + 0, 16'h0003, 1'b1);
        wr(A_ORP + 1, 16'h0002, 1'b1);
        sweep("R2");
        check_in(4'b0001, "R3");

        // R4: unmapped addresses change nothing
        for (int a = A_BR + 1; a < 32; a++) wr(a, 16'hFFFF, 1'b0);
        sweep("R4");

        // R5: growth, then complement literal -> constant 0
        wr(A_ANDF + 0, 16'h0001, 1'b1);
        sweep("R5 growth");
        wr(A_ANDF + 0, 16'h0002, 1'b1);
        sweep("R5 contradiction");
        wr(A_ANDF + 1, 16'h0040, 1'b1);
        sweep("R5 shrinkage");
        wr(A_ANDF + 0, 16'h0000, 1'b0);
        wr(A_ANDF + 1, 16'h0000, 1'b0);

        // R6: disappearance on out0, appearance on out2
        wr(A_ORF + 0, 16'h0001, 1'b1);
        wr(A_ORF + 2, 16'h0002, 1'b1);
        sweep("R6");
        clear_faults();

        // R7: input 0 stuck at 1 reaches both literals
        wr(A_ST + 0, 16'h0001, 1'b0);
        wr(A_ST + 1, 16'h0001, 1'b1);
        sweep("R7");
        clear_faults();

        // R8: complement of input 1 stuck at 0, true literal untouched
        wr(2, 16'h0004, 1'b0);
        wr(A_ORP + 2, 16'h0004, 1'b0);
        wr(A_ST + 2, 16'h0002, 1'b0);
        wr(A_ST + 3, 16'h0000, 1'b1);
        sweep("R8");
        clear_faults();

        // R11: bridge rows x3 and ~x3, lines 2 and 3
        wr(2, 16'h0040, 1'b0);
        wr(3, 16'h0080, 1'b0);
        wr(A_BR, 16'h0001 | (16'd2 << 2) | (16'd3 << 5), 1'b1);
        sweep("R11 wired-AND");
        wr(A_BR, 16'h0003 | (16'd2 << 2) | (16'd3 << 5), 1'b1);
        sweep("R11 wired-OR");
        wr(A_BR, 16'h0003 | (16'd7 << 2) | (16'd3 << 5), 1'b1);
        sweep("R11 out-of-range");

        // R9: stuck product beats the bridge
        wr(A_BR, 16'h0001 | (16'd2 << 2) | (16'd3 << 5), 1'b0);
        wr(A_ORP + 2, 16'h0008, 1'b0);
        wr(A_ST + 4, 16'h0004, 1'b0);
        wr(A_ST + 5, 16'h0004, 1'b1);
        sweep("R9");
        clear_faults();

        // R10: output 1 stuck at 1, output 0 stuck at 0
        wr(A_ST + 6, 16'h0003, 1'b0);
        wr(A_ST + 7, 16'h0002, 1'b1);
        sweep("R10");
        clear_faults();

        // Random traffic over the whole map
        for (int n = 0; n < 600; n++) begin
            if (n % 60 == 59) clear_faults();
            if ($urandom_range(1, 0) == 1)
                wr(int'($urandom_range(31, 0)), DW'($urandom), 1'b1);
            check_in(NI'($urandom), "R3 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule